// File: doc/BRIEF.md
# DMA descriptor list submission controller

This block sits between a host register port and a descriptor fetch engine. The host writes the memory address of a descriptor list and then an attribute word. The attribute word carries a slot number, a list kind, a length counted in 128-bit descriptor words and a stop flag. The block tracks eight list slots. A legal start on an idle slot goes straight to the fetch engine as a one-cycle launch pulse. A start that names a slot still in use is parked. While a start is parked, the ready flag is low and the host port takes no new list address or start until the slot frees, and then the parked start launches by itself.

Stop requests mark a running slot for release. The slot stays active until the fetch engine reports the end of its current frame. A done report from the fetch engine frees a slot at once. A malformed start (zero length or a reserved kind) is dropped and sets a sticky error bit. The host clears that bit by writing 1 to it.

Top module: `list_submit_ctrl`

## Requirements
- R1: After reset every output is low and the ready flag (attribute word bit 19) reads 0. Ready reads 1 from the cycle after `init_done_i` is first sampled high, provided no start is parked.
- R2: Register offsets on the write and read ports: 0 is the list address (read/write), 1 is the attribute word and 2 is status. The attribute word holds the slot number in 26:24, stop in 20, ready in 19, kind in 18:16 and length in 15:0. Stop, bits 31:27 and bits 23:21 read 0, and offset 3 reads 0. A list-address write or a start write made while ready is low is ignored. Every other attribute write updates the stored slot number, kind and length.
- R3: An attribute write with stop=0, while ready is high, with a legal kind and nonzero length, and naming an idle slot, produces `start_valid_o` for exactly one cycle on the next cycle. The pulse carries the stored list address, the length, the kind and the slot number. The slot's `active_o` bit is set from that same cycle.
- R4: Kinds 0 (normal), 1 (self-modifying) and 2 (doorbell) are legal; kinds 3 to 7 are reserved. A start with a reserved kind or a zero length launches nothing and leaves `active_o` unchanged. It sets status bit 0 on the next cycle. Writing 1 to status bit 0 clears it.
- R5: A legal start that names a slot still active, and not freed in the same cycle, is parked. Ready reads 0 from the next cycle, and no launch occurs.
- R6: A parked start launches on the cycle after its slot is freed. Ready reads 1 in that same cycle, and the slot stays active.
- R7: `list_done_i` with `list_done_id_i` naming an active slot clears that slot's `active_o` bit on the next cycle.
- R8: An attribute write with stop=1 naming an active slot produces `stop_valid_o` with `stop_num_o` on the next cycle, and marks the slot. The slot is freed by the next `frame_end_i` for that slot. A stop that names an idle slot is ignored. Stop writes are taken whether or not ready is high.
- R9: `frame_end_i` for a slot with no pending stop has no effect on `active_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | List manager image loaded |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wr_ofs_i | input | 2 | Write register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_ofs_i | input | 2 | Read register offset |
| reg_rdata_o | output | 32 | Read data (combinational) |
| frame_end_i | input | 1 | Fetch engine finished a frame |
| frame_end_id_i | input | 3 | Slot of the finished frame |
| list_done_i | input | 1 | Fetch engine finished a list |
| list_done_id_i | input | 3 | Slot of the finished list |
| start_valid_o | output | 1 | One-cycle launch pulse |
| start_addr_o | output | 32 | Launch list address |
| start_size_o | output | 16 | Launch length in descriptor words |
| start_type_o | output | 3 | Launch list kind |
| start_num_o | output | 3 | Launch slot number |
| stop_valid_o | output | 1 | One-cycle stop pulse |
| stop_num_o | output | 3 | Slot being stopped |
| active_o | output | 8 | Per-slot active flags |

## Verification
The bench targets a start that hits a busy slot. A design that launched it anyway would show two owners for one slot, and one that never unparked it would leave ready stuck low. It also drives a start in the same cycle that frees its slot, which a design using the stale active flag would park forever. It sends end-of-frame reports with and without a pending stop, where a wrong design frees running lists or never frees stopped ones. Further cases are zero-length and reserved-kind starts that must not claim a slot, and address writes while ready is low, which must not corrupt the address a parked start later launches with.

// File: rtl/list_submit_pkg.sv
package list_submit_pkg;
  localparam int unsigned REG_W    = 32;
  localparam logic [1:0]  OFS_ADDR = 2'd0;
  localparam logic [1:0]  OFS_ATTR = 2'd1;
  localparam logic [1:0]  OFS_STAT = 2'd2;
  localparam int unsigned NUM_LSB  = 24;
  localparam int unsigned STOP_BIT = 20;
  localparam int unsigned RDY_BIT  = 19;
  localparam int unsigned KIND_LSB = 16;
  localparam int unsigned KIND_W   = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_NORMAL   = 3'd0,
    KIND_SELFMOD  = 3'd1,
    KIND_DOORBELL = 3'd2
  } list_kind_e;

  function automatic logic kind_legal(input logic [KIND_W-1:0] k);
    return k inside {KIND_NORMAL, KIND_SELFMOD, KIND_DOORBELL};
  endfunction
endpackage

// File: rtl/list_submit_regs.sv
module list_submit_regs
  import list_submit_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned NUM_W  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_ofs_i,
  input  logic [REG_W-1:0]     wr_data_i,
  input  logic [1:0]           rd_ofs_i,
  output logic [REG_W-1:0]     rd_data_o,
  input  logic                 ready_i,
  output logic [ADDR_W-1:0]    list_addr_o,
  output logic                 start_req_o,
  output logic                 stop_req_o,
  output logic [NUM_W-1:0]     req_num_o,
  output logic [KIND_W-1:0]    req_kind_o,
  output logic [SIZE_W-1:0]    req_size_o,
  output logic                 err_o
);
  logic              attr_wr, wr_stop, legal, attr_take, bad_req, err_clr;
  logic [NUM_W-1:0]  num_q;
  logic [KIND_W-1:0] kind_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q;

  assign attr_wr    = wr_en_i && (wr_ofs_i == OFS_ATTR);
  assign wr_stop    = wr_data_i[STOP_BIT];
  assign req_num_o  = wr_data_i[NUM_LSB +: NUM_W];
  assign req_kind_o = wr_data_i[KIND_LSB +: KIND_W];
  assign req_size_o = wr_data_i[SIZE_W-1:0];
  assign legal      = (req_size_o != '0) && kind_legal(req_kind_o);
  assign attr_take  = attr_wr && (wr_stop || ready_i);
  assign start_req_o = attr_wr && !wr_stop && ready_i && legal;
  assign bad_req    = attr_wr && !wr_stop && ready_i && !legal;
  assign stop_req_o = attr_wr && wr_stop;
  assign err_clr    = wr_en_i && (wr_ofs_i == OFS_STAT) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      num_q  <= '0;
      kind_q <= '0;
      size_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en_i && (wr_ofs_i == OFS_ADDR) && ready_i) addr_q <= wr_data_i[ADDR_W-1:0];
      if (attr_take) begin
        num_q  <= req_num_o;
        kind_q <= req_kind_o;
        size_q <= req_size_o;
      end
      if (bad_req)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign list_addr_o = addr_q;
  assign err_o       = err_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_ofs_i)
      OFS_ADDR: rd_data_o[ADDR_W-1:0] = addr_q;
      OFS_ATTR: begin
        rd_data_o[NUM_LSB +: NUM_W]   = num_q;
        rd_data_o[RDY_BIT]            = ready_i;
        rd_data_o[KIND_LSB +: KIND_W] = kind_q;
        rd_data_o[SIZE_W-1:0]         = size_q;
      end
      OFS_STAT: rd_data_o[0] = err_q;
      default:  rd_data_o = '0;
    endcase
  end

  // R4: error only rises after an attribute write
  assert_err_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(attr_wr));
endmodule

// File: rtl/list_slot_table.sv
module list_slot_table #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned NUM_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] set_i,
  input  logic             stop_req_i,
  input  logic [NUM_W-1:0] stop_num_i,
  input  logic             frame_end_i,
  input  logic [NUM_W-1:0] frame_id_i,
  input  logic             done_i,
  input  logic [NUM_W-1:0] done_id_i,
  output logic [SLOTS-1:0] active_o,
  output logic [SLOTS-1:0] free_o,
  output logic             stop_valid_o,
  output logic [NUM_W-1:0] stop_num_o
);
  logic [SLOTS-1:0] active_q, pend_q, stop_take;
  logic             stop_valid_q;
  logic [NUM_W-1:0] stop_num_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic [NUM_W-1:0] ID = NUM_W'(g);
    assign free_o[g] = active_q[g] &&
                       ((done_i && done_id_i == ID) ||
                        (frame_end_i && frame_id_i == ID && pend_q[g]));
    assign stop_take[g] = stop_req_i && stop_num_i == ID && active_q[g] && !free_o[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        active_q[g] <= 1'b0;
        pend_q[g]   <= 1'b0;
      end else begin
        active_q[g] <= set_i[g] || (active_q[g] && !free_o[g]);
        pend_q[g]   <= stop_take[g] || (pend_q[g] && !free_o[g] && !set_i[g]);
      end
    end

    // R7 R8: a slot only drops on a fetch-engine report
    assert_drop_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(active_q[g]) |-> $past(done_i || frame_end_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_valid_q <= 1'b0;
      stop_num_q   <= '0;
    end else begin
      stop_valid_q <= |stop_take;
      if (stop_req_i) stop_num_q <= stop_num_i;
    end
  end

  assign active_o     = active_q;
  assign stop_valid_o = stop_valid_q;
  assign stop_num_o   = stop_num_q;

  // R8: a stop pulse always names a slot that is still held
  assert_stop_on_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_valid_q |-> active_q[stop_num_q]);
endmodule

// File: rtl/list_start_issue.sv
module list_start_issue
  import list_submit_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned NUM_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic              start_req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NUM_W-1:0]  req_num_i,
  input  logic [KIND_W-1:0] req_kind_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [SLOTS-1:0]  active_i,
  input  logic [SLOTS-1:0]  free_i,
  output logic [SLOTS-1:0]  set_o,
  output logic              ready_o,
  output logic              start_valid_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [SIZE_W-1:0] start_size_o,
  output logic [KIND_W-1:0] start_kind_o,
  output logic [NUM_W-1:0]  start_num_o
);
  logic              init_q, hold_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [SIZE_W-1:0] hold_size_q;
  logic [KIND_W-1:0] hold_kind_q;
  logic [NUM_W-1:0]  hold_num_q;
  logic              busy, go_new, go_held, launch;
  logic [NUM_W-1:0]  launch_num;

  // a slot freed this cycle counts as idle
  assign busy       = active_i[req_num_i] && !free_i[req_num_i];
  assign go_new     = start_req_i && !busy;
  assign go_held    = hold_q && free_i[hold_num_q];
  assign launch     = go_new || go_held;
  assign launch_num = go_held ? hold_num_q : req_num_i;
  assign set_o      = launch ? (SLOTS'(1) << launch_num) : '0;
  assign ready_o    = init_q && !hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q        <= 1'b0;
      hold_q        <= 1'b0;
      hold_addr_q   <= '0;
      hold_size_q   <= '0;
      hold_kind_q   <= '0;
      hold_num_q    <= '0;
      start_valid_o <= 1'b0;
      start_addr_o  <= '0;
      start_size_o  <= '0;
      start_kind_o  <= '0;
      start_num_o   <= '0;
    end else begin
      init_q        <= init_q || init_done_i;
      start_valid_o <= launch;
      if (start_req_i && busy) begin
        hold_q      <= 1'b1;
        hold_addr_q <= req_addr_i;
        hold_size_q <= req_size_i;
        hold_kind_q <= req_kind_i;
        hold_num_q  <= req_num_i;
      end else if (go_held) begin
        hold_q <= 1'b0;
      end
      if (go_held) begin
        start_addr_o <= hold_addr_q;
        start_size_o <= hold_size_q;
        start_kind_o <= hold_kind_q;
        start_num_o  <= hold_num_q;
      end else if (go_new) begin
        start_addr_o <= req_addr_i;
        start_size_o <= req_size_i;
        start_kind_o <= req_kind_i;
        start_num_o  <= req_num_i;
      end
    end
  end

  // R5: a parked start always waits on a slot that is held
  assert_hold_on_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> active_i[hold_num_q]);
  // R6: leaving the parked state coincides with a launch
  assert_unpark_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> start_valid_o);
  // R3 R4: launches never carry a zero length or reserved kind
  assert_launch_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_o |-> (start_size_o != '0) && kind_legal(start_kind_o));
endmodule

// File: rtl/list_submit_ctrl.sv
module list_submit_ctrl
  import list_submit_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned NUM_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_wr_ofs_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [1:0]        reg_rd_ofs_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              frame_end_i,
  input  logic [NUM_W-1:0]  frame_end_id_i,
  input  logic              list_done_i,
  input  logic [NUM_W-1:0]  list_done_id_i,
  output logic              start_valid_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [SIZE_W-1:0] start_size_o,
  output logic [2:0]        start_type_o,
  output logic [NUM_W-1:0]  start_num_o,
  output logic              stop_valid_o,
  output logic [NUM_W-1:0]  stop_num_o,
  output logic [SLOTS-1:0]  active_o
);
  logic              ready, start_req, stop_req, err;
  logic [ADDR_W-1:0] list_addr;
  logic [NUM_W-1:0]  req_num;
  logic [KIND_W-1:0] req_kind;
  logic [SIZE_W-1:0] req_size;
  logic [SLOTS-1:0]  set_vec, free_vec, active;

  list_submit_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .NUM_W(NUM_W)) i_regs (
    .clk_i, .rst_ni,
    .wr_en_i(reg_wr_i), .wr_ofs_i(reg_wr_ofs_i), .wr_data_i(reg_wdata_i),
    .rd_ofs_i(reg_rd_ofs_i), .rd_data_o(reg_rdata_o), .ready_i(ready),
    .list_addr_o(list_addr), .start_req_o(start_req), .stop_req_o(stop_req),
    .req_num_o(req_num), .req_kind_o(req_kind), .req_size_o(req_size), .err_o(err)
  );

  list_slot_table #(.SLOTS(SLOTS), .NUM_W(NUM_W)) i_slots (
    .clk_i, .rst_ni, .set_i(set_vec),
    .stop_req_i(stop_req), .stop_num_i(req_num),
    .frame_end_i, .frame_id_i(frame_end_id_i),
    .done_i(list_done_i), .done_id_i(list_done_id_i),
    .active_o(active), .free_o(free_vec),
    .stop_valid_o, .stop_num_o
  );

  list_start_issue #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SLOTS(SLOTS), .NUM_W(NUM_W)) i_issue (
    .clk_i, .rst_ni, .init_done_i,
    .start_req_i(start_req), .req_addr_i(list_addr), .req_num_i(req_num),
    .req_kind_i(req_kind), .req_size_i(req_size),
    .active_i(active), .free_i(free_vec), .set_o(set_vec), .ready_o(ready),
    .start_valid_o, .start_addr_o, .start_size_o, .start_kind_o(start_type_o),
    .start_num_o
  );

  assign active_o = active;

  // R3: the launched slot is marked active in the launch cycle
  assert_launch_active_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_o |-> active[start_num_o]);
  // R1: no launch before the init-done input has been seen
  assert_no_launch_pre_init_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_valid_o) |-> $past(ready || err || active != '0));
endmodule

// File: tb/test_list_submit_ctrl.sv
module test_list_submit_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, init_done = 0;
  logic        wr = 0; logic [1:0] wofs = 0; logic [31:0] wdata = 0;
  logic [1:0]  rofs = 0; logic [31:0] rdata;
  logic        fe = 0, dn = 0; logic [2:0] fid = 0, did = 0;
  logic        sv, stv; logic [31:0] saddr; logic [15:0] ssize;
  logic [2:0]  stype, snum, stn; logic [7:0] act;

  int vectors = 0, misses = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  list_submit_ctrl i_list_submit_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done),
    .reg_wr_i(wr), .reg_wr_ofs_i(wofs), .reg_wdata_i(wdata),
    .reg_rd_ofs_i(rofs), .reg_rdata_o(rdata),
    .frame_end_i(fe), .frame_end_id_i(fid), .list_done_i(dn), .list_done_id_i(did),
    .start_valid_o(sv), .start_addr_o(saddr), .start_size_o(ssize),
    .start_type_o(stype), .start_num_o(snum),
    .stop_valid_o(stv), .stop_num_o(stn), .active_o(act));

  // behavioural reference
  bit m_init, m_hold, m_err, e_sv, e_stv;
  bit [7:0] m_act, m_sp;
  bit [2:0] m_hnum, m_htype, m_num, m_type, e_snum, e_stype, e_stn;
  bit [15:0] m_hsize, m_size, e_ssize;
  bit [31:0] m_haddr, m_addr, e_saddr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_init = 0; m_hold = 0; m_err = 0; e_sv = 0; e_stv = 0;
      m_act = 0; m_sp = 0; m_addr = 0; m_num = 0; m_type = 0; m_size = 0;
    end else begin
      bit rdy, wa, ws, lg, sreq, bad, busy, go;
      bit [7:0] fr, nact, nsp;
      bit [2:0] n, t; bit [15:0] s;
      rdy = m_init && !m_hold;
      for (int i = 0; i < 8; i++)
        fr[i] = m_act[i] && ((dn && did == i) || (fe && fid == i && m_sp[i]));
      wa = wr && wofs == 2'd1; ws = wdata[20];
      n = wdata[26:24]; t = wdata[18:16]; s = wdata[15:0];
      lg = (s != 0) && (t <= 2);
      sreq = wa && !ws && rdy && lg;
      bad  = wa && !ws && rdy && !lg;
      busy = m_act[n] && !fr[n];
      go   = m_hold && fr[m_hnum];
      nact = m_act & ~fr; nsp = m_sp & ~fr;
      e_sv = 0; e_stv = 0;
      if (sreq && !busy) begin
        e_sv = 1; e_saddr = m_addr; e_ssize = s; e_stype = t; e_snum = n;
        nact[n] = 1; nsp[n] = 0;
      end
      if (go) begin
        e_sv = 1; e_saddr = m_haddr; e_ssize = m_hsize; e_stype = m_htype; e_snum = m_hnum;
        nact[m_hnum] = 1; nsp[m_hnum] = 0; m_hold = 0;
      end
      if (sreq && busy) begin
        m_hold = 1; m_haddr = m_addr; m_hsize = s; m_htype = t; m_hnum = n;
      end
      if (wa && ws && m_act[n] && !fr[n]) begin
        e_stv = 1; e_stn = n; nsp[n] = 1;
      end
      if (bad) m_err = 1;
      else if (wr && wofs == 2'd2 && wdata[0]) m_err = 0;
      if (wr && wofs == 2'd0 && rdy) m_addr = wdata;
      if (wa && (ws || rdy)) begin m_num = n; m_type = t; m_size = s; end
      m_init = m_init || init_done;
      m_act = nact; m_sp = nsp;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(int o);
    case (o)
      0: return m_addr;
      1: return {5'b0, m_num, 3'b0, 1'b0, (m_init && !m_hold), m_type, m_size};
      2: return {31'b0, m_err};
      default: return 32'b0;
    endcase
  endfunction

  task automatic compare();
    chk("R3 start_valid", sv, e_sv);
    if (e_sv) begin
      chk("R3 start_addr", saddr, e_saddr);
      chk("R3 start_size", ssize, e_ssize);
      chk("R3 start_type", stype, e_stype);
      chk("R3 start_num", snum, e_snum);
    end
    chk("R7 active", act, m_act);
    chk("R8 stop_valid", stv, e_stv);
    if (e_stv) chk("R8 stop_num", stn, e_stn);
    for (int o = 0; o < 4; o++) begin
      rofs = 2'(o); #1;
      chk("R2 readback", rdata, exp_rd(o));
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic reg_write(logic [1:0] o, logic [31:0] d);
    wr = 1; wofs = o; wdata = d; tick(); wr = 0;
  endtask

  function automatic logic [31:0] attr(int num, bit stop, int typ, int size);
    return {5'b0, 3'(num), 3'b0, stop, 1'b0, 3'(typ), 16'(size)};
  endfunction

  task automatic frame_end(int id);
    fe = 1; fid = 3'(id); tick(); fe = 0;
  endtask

  task automatic list_done(int id);
    dn = 1; did = 3'(id); tick(); dn = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    tick();
    rofs = 2'd1; #1;
    chk("R1 ready low after reset", rdata[19], 0);
    chk("R1 no start after reset", sv, 0);
    reg_write(2'd1, attr(1, 0, 0, 4));          // ignored, not ready
    chk("R1 start ignored before init", act, 8'h00);
    init_done = 1; tick(); tick();
    rofs = 2'd1; #1;
    chk("R1 ready after init", rdata[19], 1);

    reg_write(2'd0, 32'hA000_1000);
    reg_write(2'd1, attr(2, 0, 0, 4));
    chk("R3 launch slot 2", sv, 1);
    reg_write(2'd0, 32'hB000_2000);
    reg_write(2'd1, attr(5, 0, 2, 16'hFFFF));
    chk("R3 doorbell launch", {sv, 5'b0, stype}, {1'b1, 5'b0, 3'd2});
    tick();
    chk("R3 pulse single cycle", sv, 0);

    reg_write(2'd1, attr(3, 0, 1, 0));
    rofs = 2'd2; #1;
    chk("R4 zero size error", rdata[0], 1);
    chk("R4 zero size no slot", act[3], 0);
    reg_write(2'd2, 32'h1);
    reg_write(2'd1, attr(4, 0, 5, 8));
    rofs = 2'd2; #1;
    chk("R4 reserved kind error", rdata[0], 1);
    chk("R4 reserved kind no slot", act[4], 0);
    reg_write(2'd2, 32'h1);

    reg_write(2'd0, 32'hC000_3000);
    reg_write(2'd1, attr(2, 0, 1, 7));           // slot 2 busy -> park
    rofs = 2'd1; #1;
    chk("R5 ready drops on busy slot", rdata[19], 0);
    chk("R5 no launch when busy", sv, 0);
    reg_write(2'd0, 32'hDEAD_BEEF);              // ignored
    reg_write(2'd1, attr(6, 0, 0, 3));           // ignored
    chk("R5 start ignored while parked", act[6], 0);
    frame_end(2);
    chk("R9 frame end without stop", act[2], 1);
    list_done(2);
    chk("R6 parked start launches", {sv, snum}, {1'b1, 3'd2});
    chk("R6 parked start address", saddr, 32'hC000_3000);
    rofs = 2'd1; #1;
    chk("R6 ready rises with launch", rdata[19], 1);

    reg_write(2'd1, attr(5, 1, 0, 0));
    chk("R8 stop pulse", {stv, stn}, {1'b1, 3'd5});
    frame_end(3);
    chk("R8 other slot frame end", act[5], 1);
    frame_end(5);
    chk("R8 slot freed at frame end", act[5], 0);
    reg_write(2'd1, attr(7, 1, 0, 0));
    chk("R8 stop on idle slot ignored", stv, 0);

    // start in the cycle that frees its slot
    dn = 1; did = 3'd2;
    reg_write(2'd1, attr(2, 0, 0, 9));
    dn = 0;
    chk("R6 same-cycle free launches", {sv, snum}, {1'b1, 3'd2});

    // stop while parked
    reg_write(2'd1, attr(2, 0, 0, 11));
    reg_write(2'd1, attr(2, 1, 0, 0));
    chk("R8 stop accepted while parked", stv, 1);
    frame_end(2);
    chk("R6 launch after stopped frame", {sv, ssize}, {1'b1, 16'd11});

    // random traffic, checked every cycle against the model
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom_range(0, 9);
      wr = (r < 4); wofs = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) != 0) wofs = 2'd1;
      wdata = attr($urandom_range(0, 7), ($urandom_range(0, 4) == 0),
                   ($urandom_range(0, 5) == 0) ? $urandom_range(3, 7) : $urandom_range(0, 2),
                   ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 500));
      if (wofs != 2'd1) wdata = $urandom;
      fe = ($urandom_range(0, 3) == 0); fid = 3'($urandom_range(0, 7));
      dn = ($urandom_range(0, 4) == 0); did = 3'($urandom_range(0, 7));
      tick();
    end
    wr = 0; fe = 0; dn = 0;
    tick();
    finish_run();
  end
endmodule